// File: doc/BRIEF.md
# Time-Aware Trigger Window Gate

This block opens and closes the transmission gates of three egress queues that share one link: a trigger queue, a control queue and a shaped video queue. It reads a local synchronized time counter and follows a schedule that repeats with a programmable cycle time. Each cycle holds one protected trigger window, placed by an offset from the cycle start and given a width. Inside that window only the trigger queue may send. Outside it, the control queue and the video queue share the link, and control always goes first.

Just before the window there is a guard band that closes the video gate early. Each video frame that is offered also has its length checked against the time left before the guard band, or before the end of the cycle once the window is over. As a result a video burst never reaches into the trigger window. The video queue shows its head frame through a valid flag and a length in byte-times, and the block answers with a per-cycle start permission.

Schedule values are written as a set. A set that is accepted waits in a shadow copy and becomes active only at the next cycle boundary. A set that cannot fit in its own cycle is refused, and an error flag is raised.

Top module: `trig_window_gate`

## Requirements
- R1: After reset the active schedule holds the parameter defaults, the cycle origin is time 0 and cfg_err is 0. At time 0 the control gate is open and the trigger gate is closed.
- R2: Cycle boundaries fall at time 0 and then every cycle-length time units later. The phase is time minus the last boundary, and it is always smaller than the active cycle length.
- R3: gate_trg is 1 exactly when the phase p satisfies offset <= p < offset + width.
- R4: gate_ctl is 1 exactly when gate_trg is 0.
- R5: gate_vid is 0 inside the trigger window and inside the guard band offset - guard <= p < offset.
- R6: Outside the window and the guard band, a video frame of length L may start only if p + L <= offset - guard (before the window) or p + L <= cycle (after the window). Otherwise the frame is held.
- R7: While ctl_req is 1, gate_vid is 0. This gives control strict priority over video.
- R8: While vid_vld is 0, gate_vid is 0.
- R9: An accepted schedule write changes nothing in the current cycle. It becomes active from the first boundary after the write edge. A later accepted write replaces an earlier pending one.
- R10: A write is refused when cycle is 0, width is 0, offset + width > cycle, or guard > offset. A refused write leaves both the active and the pending schedule unchanged and sets cfg_err from the next cycle. cfg_err stays set until an accepted write clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| time_now | input | TIME_W | Local synchronized time in byte-time units, advances by less than one cycle per clock |
| cfg_wr | input | 1 | Write strobe for the schedule set |
| cfg_cycle | input | 16 | Cycle length |
| cfg_offset | input | 16 | Trigger window start within the cycle |
| cfg_width | input | 16 | Trigger window length |
| cfg_guard | input | 16 | Guard band length ahead of the window |
| ctl_req | input | 1 | Control queue has a frame waiting |
| vid_vld | input | 1 | Video queue head frame is present |
| vid_len | input | 16 | Length of the video head frame in byte-times |
| cfg_err | output | 1 | Last schedule write was refused |
| gate_trg | output | 1 | Trigger queue may transmit |
| gate_ctl | output | 1 | Control queue may transmit |
| gate_vid | output | 1 | Video head frame may start now |

## Verification
The gates are decoded combinationally from the current time, so a wrong cycle origin or a wrong active schedule shows up in the same clock as a window that is shifted, stretched or missing on gate_trg and gate_ctl. A boundary that is missed or doubled moves every later window by a whole cycle, which the next expected window opening exposes. An error in the shadow handling shows up as a window that moves too early or never moves, as a pending set that a refused write has corrupted, or as cfg_err that is wrong one clock after a write. A wrong fit limit shows up on gate_vid close to the guard start and the cycle end, so frame lengths are chosen to cross those edges.

// File: rtl/twg_pkg.sv
package twg_pkg;

  parameter int unsigned TWG_CW = 16;

  typedef struct packed {
    logic [TWG_CW-1:0] cycle;
    logic [TWG_CW-1:0] offset;
    logic [TWG_CW-1:0] width;
    logic [TWG_CW-1:0] guard;
  } twg_sched_t;

  // Schedule is usable when the window and its guard band fit inside one cycle.
  function automatic logic sched_ok(twg_sched_t s);
    logic [TWG_CW:0] win_end;
    win_end = {1'b0, s.offset} + {1'b0, s.width};
    return (s.cycle != '0) && (s.width != '0) &&
           (win_end <= {1'b0, s.cycle}) && (s.guard <= s.offset);
  endfunction

endpackage

// File: rtl/twg_cfg.sv
module twg_cfg
  import twg_pkg::*;
#(
  parameter twg_sched_t DEF_SCHED = '{cycle: 16'd100, offset: 16'd40, width: 16'd10, guard: 16'd16}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  twg_sched_t wr_sched,
  input  logic       wrap,
  output twg_sched_t act_o,
  output twg_sched_t cur_o,
  output logic       err_o
);

  twg_sched_t act_q, act_n;
  twg_sched_t pend_q, pend_n;
  logic       pvld_q, pvld_n;
  logic       err_q, err_n;
  logic       wr_good;

  assign wr_good = sched_ok(wr_sched);

  always_comb begin
    act_n  = act_q;
    pend_n = pend_q;
    pvld_n = pvld_q;
    err_n  = err_q;
    if (wrap && pvld_q) begin
      act_n = pend_q;
    end
    if (wrap) begin
      pvld_n = 1'b0;
    end
    if (wr_en) begin
      if (wr_good) begin
        pend_n = wr_sched;
        pvld_n = 1'b1;
        err_n  = 1'b0;
      end else begin
        err_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= DEF_SCHED;
      pend_q <= DEF_SCHED;
      pvld_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      act_q  <= act_n;
      pend_q <= pend_n;
      pvld_q <= pvld_n;
      err_q  <= err_n;
    end
  end

  assign act_o = act_q;
  assign cur_o = (wrap && pvld_q) ? pend_q : act_q;
  assign err_o = err_q;

  // R9
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_q));

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(wr_en));

  // R10
  act_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, act_q.offset} + {1'b0, act_q.width}) <= {1'b0, act_q.cycle}) &&
    (act_q.guard <= act_q.offset));

endmodule

// File: rtl/twg_phase.sv
module twg_phase #(
  parameter int unsigned TIME_W = 32,
  parameter int unsigned CW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic [CW-1:0]     cyc,
  output logic              wrap,
  output logic [CW-1:0]     phase
);

  localparam int unsigned PADW = TIME_W - CW;

  logic [TIME_W-1:0] base_q, base_n;
  logic [TIME_W-1:0] raw;
  logic [TIME_W-1:0] cyc_x;

  assign cyc_x = {{PADW{1'b0}}, cyc};
  assign raw   = time_now - base_q;
  assign wrap  = (raw >= cyc_x);
  assign phase = CW'(wrap ? (raw - cyc_x) : raw);

  always_comb begin
    base_n = base_q;
    if (wrap) begin
      base_n = base_q + cyc_x;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else begin
      base_q <= base_n;
    end
  end

endmodule

// File: rtl/twg_gate.sv
module twg_gate
  import twg_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] phase,
  input  twg_sched_t    sched,
  input  logic          ctl_req,
  input  logic          vid_vld,
  input  logic [CW-1:0] vid_len,
  output logic          gate_trg,
  output logic          gate_ctl,
  output logic          gate_vid
);

  logic [CW:0] p_x, win_lo, win_hi, grd_lo, limit, end_x;
  logic        in_win, in_grd, fits;

  always_comb begin
    p_x    = {1'b0, phase};
    win_lo = {1'b0, sched.offset};
    win_hi = {1'b0, sched.offset} + {1'b0, sched.width};
    grd_lo = {1'b0, sched.offset} - {1'b0, sched.guard};
    in_win = (p_x >= win_lo) && (p_x < win_hi);
    in_grd = (p_x >= grd_lo) && (p_x < win_lo);
    limit  = (p_x < win_lo) ? grd_lo : {1'b0, sched.cycle};
    end_x  = p_x + {1'b0, vid_len};
    fits   = (end_x <= limit);
  end

  assign gate_trg = in_win;
  assign gate_ctl = !in_win;
  assign gate_vid = !in_win && !in_grd && fits && vid_vld && !ctl_req;

  // R5
  vid_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_vid |-> !gate_trg);

  // R7
  vid_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_vid |-> !ctl_req);

  // R6
  vid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_vid |-> (({1'b0, phase} + {1'b0, vid_len}) <= {1'b0, sched.cycle}));

  // R2
  phase_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase < sched.cycle);

endmodule

// File: rtl/trig_window_gate.sv
module trig_window_gate
  import twg_pkg::*;
#(
  parameter int unsigned TIME_W    = 32,
  parameter int unsigned DEF_CYCLE = 100,
  parameter int unsigned DEF_OFF   = 40,
  parameter int unsigned DEF_WID   = 10,
  parameter int unsigned DEF_GUARD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic              cfg_wr,
  input  logic [15:0]       cfg_cycle,
  input  logic [15:0]       cfg_offset,
  input  logic [15:0]       cfg_width,
  input  logic [15:0]       cfg_guard,
  input  logic              ctl_req,
  input  logic              vid_vld,
  input  logic [15:0]       vid_len,
  output logic              cfg_err,
  output logic              gate_trg,
  output logic              gate_ctl,
  output logic              gate_vid
);

  localparam int unsigned CW = TWG_CW;
  localparam twg_sched_t DEF_SCHED = '{cycle:  CW'(DEF_CYCLE),
                                       offset: CW'(DEF_OFF),
                                       width:  CW'(DEF_WID),
                                       guard:  CW'(DEF_GUARD)};

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  twg_sched_t wr_sched, act_sched, cur_sched;
  logic       wrap;
  logic [CW-1:0] phase;

  assign wr_sched = '{cycle: cfg_cycle, offset: cfg_offset, width: cfg_width, guard: cfg_guard};

  twg_cfg #(.DEF_SCHED(DEF_SCHED)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (cfg_wr),
    .wr_sched (wr_sched),
    .wrap     (wrap),
    .act_o    (act_sched),
    .cur_o    (cur_sched),
    .err_o    (cfg_err)
  );

  twg_phase #(.TIME_W(TIME_W), .CW(CW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .time_now (time_now),
    .cyc      (act_sched.cycle),
    .wrap     (wrap),
    .phase    (phase)
  );

  twg_gate #(.CW(CW)) u_gate (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .phase    (phase),
    .sched    (cur_sched),
    .ctl_req  (ctl_req),
    .vid_vld  (vid_vld),
    .vid_len  (vid_len),
    .gate_trg (gate_trg),
    .gate_ctl (gate_ctl),
    .gate_vid (gate_vid)
  );

  // R4
  trg_ctl_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({gate_trg, gate_ctl | gate_vid}));

endmodule

// File: tb/tb_trig_window_gate.sv
`timescale 1ns/1ps
module tb_trig_window_gate;

  logic        clk;
  logic        rst_n;
  logic [31:0] time_now;
  logic        cfg_wr;
  logic [15:0] cfg_cycle, cfg_offset, cfg_width, cfg_guard;
  logic        ctl_req, vid_vld;
  logic [15:0] vid_len;
  logic        cfg_err, gate_trg, gate_ctl, gate_vid;

  trig_window_gate dut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .cfg_wr(cfg_wr), .cfg_cycle(cfg_cycle), .cfg_offset(cfg_offset),
    .cfg_width(cfg_width), .cfg_guard(cfg_guard),
    .ctl_req(ctl_req), .vid_vld(vid_vld), .vid_len(vid_len),
    .cfg_err(cfg_err), .gate_trg(gate_trg), .gate_ctl(gate_ctl), .gate_vid(gate_vid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done = 0;
  int unsigned t = 0;

  // reference model state
  int unsigned mbase;
  int unsigned ac, ao, aw, ag;
  int unsigned pc, po, pw, pg;
  bit          mpv, merr;

  function automatic bit sched_good(int unsigned c, int unsigned o, int unsigned w, int unsigned g);
    return (c != 0) && (w != 0) && (o + w <= c) && (g <= o);
  endfunction

  task automatic chk(bit got, bit exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at time unit %0d", tag, got, exp, t);
    end
  endtask

  task automatic do_step(bit wr, int unsigned c, int unsigned o, int unsigned w, int unsigned g,
                         bit ctl, bit vv, int unsigned len);
    int unsigned raw, p, cc, co, cw, cg, lim;
    bit wrp, etrg, egrd, efit, evid;
    string vtag;
    @(negedge clk);
    time_now   = t;
    cfg_wr     = wr;
    cfg_cycle  = c[15:0];
    cfg_offset = o[15:0];
    cfg_width  = w[15:0];
    cfg_guard  = g[15:0];
    ctl_req    = ctl;
    vid_vld    = vv;
    vid_len    = len[15:0];
    #1;
    raw = t - mbase;
    wrp = (raw >= ac);
    if (wrp && mpv) begin cc = pc; co = po; cw = pw; cg = pg; end
    else            begin cc = ac; co = ao; cw = aw; cg = ag; end
    p    = wrp ? raw - ac : raw;
    etrg = (p >= co) && (p < co + cw);
    egrd = (p + cg >= co) && (p < co);
    lim  = (p < co) ? co - cg : cc;
    efit = (p + len <= lim);
    evid = !etrg && !egrd && vv && efit && !ctl;
    if (etrg || egrd) vtag = "R5";
    else if (ctl)     vtag = "R7";
    else if (!vv)     vtag = "R8";
    else              vtag = "R6";
    chk(gate_trg, etrg, "R3");
    chk(gate_ctl, !etrg, "R4");
    chk(gate_vid, evid, vtag);
    chk(cfg_err, merr, "R10");
    // model of the coming edge
    if (wrp) begin
      mbase = mbase + ac;
      if (mpv) begin ac = pc; ao = po; aw = pw; ag = pg; end
    end
    if (wr) begin
      if (sched_good(c, o, w, g)) begin
        pc = c; po = o; pw = w; pg = g; mpv = 1; merr = 0;
      end else begin
        merr = 1;
        if (wrp) mpv = 0;
      end
    end else if (wrp) begin
      mpv = 0;
    end
    t++;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0; time_now = '0; cfg_wr = 0; cfg_cycle = '0; cfg_offset = '0;
    cfg_width = '0; cfg_guard = '0; ctl_req = 0; vid_vld = 0; vid_len = '0;
    mbase = 0; ac = 100; ao = 40; aw = 10; ag = 16;
    pc = 100; po = 40; pw = 10; pg = 16; mpv = 0; merr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: defaults at time 0
    do_step(0, 0, 0, 0, 0, 0, 0, 0);
    chk(cfg_err, 1'b0, "R1");
    chk(gate_ctl, 1'b1, "R1");
    chk(gate_trg, 1'b0, "R1");

    for (int s = 0; s < 3000; s++) begin
      bit wr, ctl, vv;
      int unsigned c, o, w, g, len;
      wr = 0; c = 0; o = 0; w = 0; g = 0;
      ctl = ($urandom % 4 == 0);
      vv  = ($urandom % 4 != 0);
      len = 1 + ($urandom % 40);
      if (t == 420) begin wr = 1; c = 60; o = 10; w = 5; g = 8; end
      else if (t == 450) begin wr = 1; c = 60; o = 30; w = 40; g = 4; end
      else if (t == 530) begin wr = 1; c = 80; o = 5; w = 5; g = 9; end
      else if (t == 560) begin wr = 1; c = 0; o = 0; w = 1; g = 0; end
      else if (t >= 600 && ($urandom % 40 == 0)) begin
        wr = 1;
        c = $urandom % 120;
        o = $urandom % (c + 1);
        w = $urandom % 25;
        g = $urandom % 25;
      end
      do_step(wr, c, o, w, g, ctl, vv, len);
      // directed corner checks; t was advanced inside the step
      case (t - 1)
        239: chk(gate_trg, 1'b0, "R2");
        240: chk(gate_trg, 1'b1, "R2");
        249: chk(gate_trg, 1'b1, "R2");
        250: chk(gate_trg, 1'b0, "R2");
        440: chk(gate_trg, 1'b1, "R9");
        505: chk(gate_trg, 1'b0, "R9");
        510: chk(gate_trg, 1'b1, "R9");
        451: chk(cfg_err, 1'b1, "R10");
        515: chk(gate_trg, 1'b0, "R10");
        default: ;
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule